// File: doc/BRIEF.md
# CAN Error Confinement Status and Interrupt Flag Unit

This unit sits next to a CAN protocol core. Each clock it takes the core's transmit and receive error counters and a vector of one-cycle protocol error pulses. From the counters it derives three confinement levels: warning, passive and bus-off. It keeps a status word that shows those levels, together with sticky bits for each kind of protocol error. It also keeps a word of interrupt flags that record when each level was entered.

A small register port gives software three words: status, flags and mask. Reads are combinational. Writes take effect at the next clock edge. Sticky bits are cleared by writing ones to them. The mask word enables each level flag and each of two interrupt lines. One select bit in the mask word steers all of these system interrupts to line 0 or to line 1. Bus-off is cleared only by a software-reset pulse.

Top module: `can_err_unit`

## Requirements
- R1: Status bit 16 (warning) reads 1 exactly when, at the previous clock edge, the transmit or the receive counter was at least 96.
- R2: Status bit 17 (passive) reads 1 exactly when, at the previous clock edge, the transmit or the receive counter was at least 128.
- R3: Status bit 18 (bus-off) sets one cycle after the transmit counter exceeds 255. It then stays set until a cycle with `sw_rst_i` high and the transmit counter at 255 or below. A receive counter above 255 never sets it, and writing 1 to bit 18 has no effect.
- R4: Protocol error pulse bit k of `proto_err_i` sets sticky status bit 19+k (k=0 ack, 1 stuff, 2 CRC, 3 stuck-dominant, 4 bit, 5 form). Writing 1 to that bit at address 0 clears it. A pulse in the same cycle as the clear leaves the bit set.
- R5: Flag bits 8, 9 and 10 (warning, passive, bus-off) set only in the cycle in which the matching status level rises. After a clear, a flag stays 0 while its level merely persists.
- R6: Writing 1s to flag bits 8 to 10 at address 1 clears them, and a rise in the same cycle wins. All other bits at address 1 read 0.
- R7: The mask word resets to 0x700. Only bits 0 (line 0 enable), 1 (line 1 enable), 2 (route to line 1) and 8 to 10 (flag enables) are writable. All other bits read 0.
- R8: `irq_o[0]` = bit0 & !bit2 & any, and `irq_o[1]` = bit1 & bit2 & any, where any is the OR of the flags ANDed with mask bits 8 to 10. The lines follow the register contents in the same cycle.
- R9: Address 0 reads status, 1 reads flags, 2 reads the mask, and 3 reads 0. After reset, status and flags read 0.
- R10: Writes to status bits 16 and 17 have no effect, because these bits always show the live counter levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_cnt_i | input | CNT_W | Transmit error counter from the core |
| rx_err_cnt_i | input | CNT_W | Receive error counter from the core |
| proto_err_i | input | 6 | One-cycle protocol error pulses (ack, stuff, CRC, stuck, bit, form) |
| sw_rst_i | input | 1 | Software reset pulse; releases bus-off |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 flags, 2 mask) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
Counter levels, protocol pulses and register writes are sampled at a rising edge, and their effect on status, flags and mask is visible one cycle later. The interrupt lines follow those registers with no further delay, and reads have zero latency. The bench therefore drives every stimulus at a falling edge and samples after exactly one rising edge. Its model advances by one step per edge, in lockstep with the design, so each comparison falls in the cycle in which the result is due.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    localparam int unsigned NUM_PERR   = 6;
    localparam int unsigned NUM_LINES  = 2;
    localparam int unsigned NUM_LVL    = 3;

    // bit positions that software decodes
    localparam int unsigned ST_LVL_LSB = 16;
    localparam int unsigned ST_ERR_LSB = 19;
    localparam int unsigned FL_LSB     = 8;
    localparam int unsigned MK_EN_LSB  = 0;
    localparam int unsigned MK_SEL     = 2;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_FLAGS  = 2'd1,
        A_MASK   = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;

    // bit 0 warning, bit 1 passive, bit 2 bus-off
    typedef struct packed {
        logic boff;
        logic pass;
        logic warn;
    } lvl_t;

    typedef struct packed {
        logic [NUM_PERR-1:0]  err;
        lvl_t                 flg;
        lvl_t                 men;
        logic                 sel;
        logic [NUM_LINES-1:0] en;
    } regs_t;

endpackage

// File: rtl/can_err_level.sv
module can_err_level
    import can_err_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned WARN_LVL = 96,
    parameter int unsigned PASS_LVL = 128,
    parameter int unsigned BOFF_LVL = 255
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             sw_rst_i,
    output lvl_t             lvl_o,
    output lvl_t             rise_o
);

    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LVL);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LVL);
    localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BOFF_LVL);

    lvl_t lvl_d, lvl_q;

    always_comb begin
        lvl_d      = lvl_q;
        lvl_d.warn = (tx_cnt_i >= WARN_C) || (rx_cnt_i >= WARN_C);
        lvl_d.pass = (tx_cnt_i >= PASS_C) || (rx_cnt_i >= PASS_C);
        // only the transmit side can drive the node off the bus
        lvl_d.boff = (tx_cnt_i > BOFF_C) || (lvl_q.boff && !sw_rst_i);
        rise_o     = lvl_t'(lvl_d & ~lvl_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/can_err_regs.sv
module can_err_regs
    import can_err_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  lvl_t                 lvl_i,
    input  lvl_t                 rise_i,
    input  logic [NUM_PERR-1:0]  proto_err_i,
    input  logic                 wr_i,
    input  reg_addr_e            addr_i,
    input  logic [31:0]          wdata_i,
    output logic [31:0]          rdata_o,
    output lvl_t                 flg_o,
    output lvl_t                 men_o,
    output logic                 sel_o,
    output logic [NUM_LINES-1:0] en_o
);

    localparam regs_t REGS_RST = '{
        err: '0,
        flg: lvl_t'('0),
        men: lvl_t'(3'b111),
        sel: 1'b0,
        en:  '0
    };

    regs_t r_d, r_q;
    logic  unused_wdata;

    assign unused_wdata = ^{wdata_i[31:25], wdata_i[18:11], wdata_i[7:3]};

    always_comb begin
        r_d = r_q;
        // sticky protocol errors: clear first, a new pulse wins
        if (wr_i && addr_i == A_STATUS) begin
            r_d.err = r_q.err & ~wdata_i[ST_ERR_LSB +: NUM_PERR];
        end
        r_d.err = r_d.err | proto_err_i;
        // level-change flags: clear first, a new rise wins
        if (wr_i && addr_i == A_FLAGS) begin
            r_d.flg = lvl_t'(r_q.flg & ~wdata_i[FL_LSB +: NUM_LVL]);
        end
        r_d.flg = lvl_t'(r_d.flg | rise_i);
        if (wr_i && addr_i == A_MASK) begin
            r_d.men = lvl_t'(wdata_i[FL_LSB +: NUM_LVL]);
            r_d.sel = wdata_i[MK_SEL];
            r_d.en  = wdata_i[MK_EN_LSB +: NUM_LINES];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_STATUS: begin
                rdata_o[ST_LVL_LSB +: NUM_LVL]  = lvl_i;
                rdata_o[ST_ERR_LSB +: NUM_PERR] = r_q.err;
            end
            A_FLAGS: begin
                rdata_o[FL_LSB +: NUM_LVL] = r_q.flg;
            end
            A_MASK: begin
                rdata_o[FL_LSB +: NUM_LVL]       = r_q.men;
                rdata_o[MK_SEL]                  = r_q.sel;
                rdata_o[MK_EN_LSB +: NUM_LINES]  = r_q.en;
            end
            default: begin
                rdata_o = '0;
            end
        endcase
    end

    assign flg_o = r_q.flg;
    assign men_o = r_q.men;
    assign sel_o = r_q.sel;
    assign en_o  = r_q.en;

endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
    import can_err_pkg::*;
(
    input  lvl_t                 flg_i,
    input  lvl_t                 men_i,
    input  logic                 sel_i,
    input  logic [NUM_LINES-1:0] en_i,
    output logic [NUM_LINES-1:0] irq_o
);

    logic any_s;

    assign any_s = |(flg_i & men_i);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign irq_o[l] = en_i[l] && (int'(sel_i) == l) && any_s;
    end

endmodule

// File: rtl/can_err_unit.sv
module can_err_unit
    import can_err_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned WARN_LVL = 96,
    parameter int unsigned PASS_LVL = 128,
    parameter int unsigned BOFF_LVL = 255
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [CNT_W-1:0]     tx_err_cnt_i,
    input  logic [CNT_W-1:0]     rx_err_cnt_i,
    input  logic [5:0]           proto_err_i,
    input  logic                 sw_rst_i,
    input  logic                 reg_wr_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    output logic [1:0]           irq_o
);

    lvl_t                 lvl_s, rise_s, flg_s, men_s;
    logic                 sel_s;
    logic [NUM_LINES-1:0] en_s;

    can_err_level #(
        .CNT_W    (CNT_W),
        .WARN_LVL (WARN_LVL),
        .PASS_LVL (PASS_LVL),
        .BOFF_LVL (BOFF_LVL)
    ) i_level (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tx_cnt_i (tx_err_cnt_i),
        .rx_cnt_i (rx_err_cnt_i),
        .sw_rst_i (sw_rst_i),
        .lvl_o    (lvl_s),
        .rise_o   (rise_s)
    );

    can_err_regs i_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl_i       (lvl_s),
        .rise_i      (rise_s),
        .proto_err_i (proto_err_i),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_e'(reg_addr_i)),
        .wdata_i     (reg_wdata_i),
        .rdata_o     (reg_rdata_o),
        .flg_o       (flg_s),
        .men_o       (men_s),
        .sel_o       (sel_s),
        .en_o        (en_s)
    );

    can_err_irq i_irq (
        .flg_i (flg_s),
        .men_i (men_s),
        .sel_i (sel_s),
        .en_i  (en_s),
        .irq_o (irq_o)
    );

endmodule

// File: rtl/can_err_unit_chk.sv
module can_err_unit_chk #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned WARN_LVL = 96,
    parameter int unsigned PASS_LVL = 128,
    parameter int unsigned BOFF_LVL = 255
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] tx_i,
    input logic [CNT_W-1:0] rx_i,
    input logic             sw_rst_i,
    input logic [1:0]       irq_i,
    input logic [2:0]       lvl_i,
    input logic [2:0]       flg_i,
    input logic [2:0]       men_i
);

    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LVL);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LVL);
    localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BOFF_LVL);

    a_r1_warn_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> lvl_i[0] == (($past(tx_i) >= WARN_C) || ($past(rx_i) >= WARN_C)));

    a_r2_pass_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> lvl_i[1] == (($past(tx_i) >= PASS_C) || ($past(rx_i) >= PASS_C)));

    a_r3_boff_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_i[2] && !sw_rst_i) |=> lvl_i[2]);

    a_r3_boff_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((tx_i <= BOFF_C) && (!lvl_i[2] || sw_rst_i)) |=> !lvl_i[2]);

    a_r5_warn_flag_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flg_i[0]) |-> $rose(lvl_i[0]));

    a_r5_boff_flag_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flg_i[2]) |-> $rose(lvl_i[2]));

    a_r8_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_i[0] && irq_i[1]));

    a_r8_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_i) |-> (|(flg_i & men_i)));

endmodule

bind can_err_unit can_err_unit_chk #(
    .CNT_W    (CNT_W),
    .WARN_LVL (WARN_LVL),
    .PASS_LVL (PASS_LVL),
    .BOFF_LVL (BOFF_LVL)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_i     (tx_err_cnt_i),
    .rx_i     (rx_err_cnt_i),
    .sw_rst_i (sw_rst_i),
    .irq_i    (irq_o),
    .lvl_i    (lvl_s),
    .flg_i    (flg_s),
    .men_i    (men_s)
);

// File: tb/test_can_err_unit.sv
module test_can_err_unit;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [8:0]  tx = '0;
    logic [8:0]  rx = '0;
    logic [5:0]  perr = '0;
    logic        swr = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad   = 0;

    // bench model state
    logic        m_warn = 0, m_pass = 0, m_boff = 0;
    logic [2:0]  m_flg = '0;
    logic [5:0]  m_err = '0;
    logic [31:0] m_mask = 32'h700;

    always #10 clk = ~clk;

    can_err_unit i_can_err_unit (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .tx_err_cnt_i (tx),
        .rx_err_cnt_i (rx),
        .proto_err_i  (perr),
        .sw_rst_i     (swr),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance model and design by one rising edge; pulses last one cycle
    task automatic step();
        logic nw, np, nb;
        logic [2:0] rise;
        nw = (tx >= 96) || (rx >= 96);
        np = (tx >= 128) || (rx >= 128);
        nb = (tx > 255) || (m_boff && !swr);
        rise = {nb && !m_boff, np && !m_pass, nw && !m_warn};
        if (wr && addr == 2'd1) m_flg = m_flg & ~wdata[10:8];
        m_flg = m_flg | rise;
        if (wr && addr == 2'd0) m_err = m_err & ~wdata[24:19];
        m_err = m_err | perr;
        if (wr && addr == 2'd2) m_mask = wdata & 32'h707;
        m_warn = nw; m_pass = np; m_boff = nb;
        @(posedge clk);
        @(negedge clk);
        wr = 0; perr = '0; swr = 0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1;
        step();
    endtask

    task automatic check_all(input string ctx);
        logic any;
        logic [1:0] eirq;
        any = |(m_flg & m_mask[10:8]);
        eirq = {m_mask[1] & m_mask[2] & any, m_mask[0] & ~m_mask[2] & any};
        addr = 2'd0; #1;
        chk({"R1/R2/R3/R4/R10 status ", ctx}, rdata,
            {7'b0, m_err, m_boff, m_pass, m_warn, 16'b0});
        addr = 2'd1; #1;
        chk({"R5/R6 flags ", ctx}, rdata, {21'b0, m_flg, 8'b0});
        addr = 2'd2; #1;
        chk({"R7 mask ", ctx}, rdata, m_mask);
        addr = 2'd3; #1;
        chk({"R9 unmapped ", ctx}, rdata, 32'h0);
        chk({"R8 irq ", ctx}, {30'b0, irq}, {30'b0, eirq});
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1;
        @(negedge clk);
        check_all("R9 after reset");

        // R1 R2 R3 R5: transmit counter sweep through all thresholds
        for (int t = 0; t <= 300; t++) begin
            tx = 9'(t);
            step();
            check_all("tx sweep");
        end
        tx = 0;
        step();
        check_all("R3 boff held at tx 0");
        // R3 R10: writing ones to level bits changes nothing
        tx = 100;
        step();
        wreg(2'd0, 32'h0007_0000);
        check_all("R3/R10 level write ignored");
        swr = 1; tx = 0;
        step();
        check_all("R3 sw reset releases");

        // R3: receive counter sweep never causes bus-off
        for (int r = 0; r < 512; r++) begin
            rx = 9'(r);
            step();
            check_all("rx sweep");
        end
        rx = 0;
        step();

        // R1 R2 R3: boundary combinations of both counters
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [8:0] pts [8];
                pts = '{9'd0, 9'd95, 9'd96, 9'd127, 9'd128, 9'd255, 9'd256, 9'd511};
                tx = pts[a]; rx = pts[b];
                step();
                check_all("counter corners");
                swr = (b == 7);
            end
        end
        tx = 0; rx = 0; swr = 1;
        step();
        wreg(2'd1, 32'h0000_0700);
        check_all("clean state");

        // R4: each protocol error latches, clears, and wins over a clear
        for (int k = 0; k < 6; k++) begin
            perr = 6'(1 << k);
            step();
            check_all("R4 latch");
            wreg(2'd0, 32'(1) << (19 + k));
            check_all("R4 clear");
            perr = 6'(1 << k);
            wreg(2'd0, 32'(1) << (19 + k));
            check_all("R4 set wins");
            wreg(2'd0, 32'h01F8_0000);
            check_all("R4 clear all");
        end

        // R5: flag does not reassert while the level persists
        tx = 100;
        step();
        check_all("R5 warning flag set");
        wreg(2'd1, 32'h0000_0700);
        for (int i = 0; i < 5; i++) begin
            step();
            check_all("R5 persist no reflag");
        end

        // R8 R7 R6: every flag subset against every mask setting
        for (int f = 0; f < 8; f++) begin
            swr = 1; tx = 0; rx = 0;
            step();
            wreg(2'd1, 32'hFFFF_FFFF);
            tx = 300;
            step();
            wreg(2'd1, 32'(~f & 7) << 8);
            check_all("R6 flag subset");
            for (int m = 0; m < 64; m++) begin
                wreg(2'd2, 32'hFFFF_F8F8 | (32'(m >> 3) << 8) | 32'(m & 7));
                check_all("R8 routing");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule